// File: doc/BRIEF.md
# Full-RAM 16 kB Paging Controller

This block adds a second meaning to the interface's paging control register. When software writes a value that keeps the "force ROM" bit low and bank-select bit 1 high, the write-protected RAM mode must be in force and the protection jumper must be open. In that case the block leaves the usual ROM-plus-8 kB-bank arrangement. It then presents one 16 kB window of RAM, made from two adjacent 8 kB banks, over the whole 0000h–3FFFh region. While the block is in this mode, the control register has a new layout. Bit 7 is an exit request, bit 6 turns on writes to the window, and bit 0 picks the bank pair. The other bits have no effect.

While the mode is active, the code-fetch entry points no longer map memory. They control whether the front-panel NMI is allowed. An opcode fetch from a trap address blocks the NMI. The NMI is allowed again by the refresh cycle that follows a fetch from the top eight bytes of the first 8 kB. The decoding of the standard layout lives in a neighbouring block. This block only decides whether the full-RAM mode is active and what it presents while it is.

Top module: `allram_pager`

## Requirements
- R1: A register write with data bit 7 = 0 and bit 1 = 1 enters the mode on the next cycle, but only when the jumper is open and either `mapram_i` is high or data bit 6 is 1. On entry, write enable takes the value of data bit 6, the pair select is 0 and the exit state is 0. For example, a write of 42h enters with the window writable.
- R2: While in the mode, a write with bit 7 = 0 sets write enable from bit 6 and the pair select from bit 0 (0 gives banks 0+1, 1 gives banks 2+3). Bits 5..1 have no effect.
- R3: `ram_we_o` and `pair_sel_o` are 0 whenever the mode is inactive. While the mode is active they show the stored write enable and pair select.
- R4: While in the mode, a write with bit 7 = 1 leaves the mode on the next cycle.
- R5: After leaving, a later standard-layout write that meets the R1 condition enters the mode again.
- R6: A closed jumper (`jumper_open_i` = 0) drops `allram_o` in the same cycle. The mode stays off when the jumper reopens, until a new write meets the R1 condition.
- R7: In the mode, an opcode fetch (`fetch_i`) from 0000h, 0008h, 0038h, 0066h, 04C6h, 0562h or any address in 3D00h–3DFFh drives `nmi_en_o` low from the next cycle.
- R8: In the mode, a fetch from 1FF8h–1FFFh arms a re-enable, and the following `rfsh_i` cycle drives `nmi_en_o` high from the next cycle. The fetch alone does not enable the NMI, and a refresh cycle that is not armed has no effect.
- R9: `nmi_en_o` is 1 whenever the mode is inactive, and on each entry to the mode the NMI starts out enabled.
- R10: After reset the mode is inactive, `ram_we_o` and `pair_sel_o` are 0 and `nmi_en_o` is 1.
- R11: From the inactive state, a write that fails any part of the R1 condition leaves the mode inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Control register write strobe, one cycle |
| reg_wdata_i | input | 8 | Control register write data |
| mapram_i | input | 1 | Write-protected RAM mode currently set in the standard register |
| jumper_open_i | input | 1 | Protection jumper open (1) or closed (0) |
| fetch_i | input | 1 | Opcode fetch cycle qualifier |
| rfsh_i | input | 1 | Refresh cycle qualifier |
| fetch_addr_i | input | 16 | Address of the opcode fetch |
| allram_o | output | 1 | Full-RAM mode active |
| pair_sel_o | output | 1 | Selected bank pair (0: banks 0+1, 1: banks 2+3) |
| ram_we_o | output | 1 | RAM window writable |
| nmi_en_o | output | 1 | NMI button allowed |

## Verification
The embedded properties check the register transitions on every cycle. These are entry, field update, exit, the one-cycle clear caused by a closed jumper, and the hold of the inactive state. They also check the NMI gate's single-cycle reactions to trap fetches, armed refreshes and mode exit. Some results can only be shown by the bench scenarios. One is the full classification of trap and off-area addresses across the lower 16 kB. Another is that the output gating drops in the same cycle as the jumper closes. A third is that an exit followed by a re-entry restores a clean NMI state.

// File: rtl/allram_pkg.sv
package allram_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // standard layout bits used to detect the activation write
    localparam int STD_FORCE_BIT  = 7;
    localparam int STD_PROT_BIT   = 6;
    localparam int STD_BANKHI_BIT = 1;

    // full-RAM layout bits
    localparam int FR_EXIT_BIT = 7;
    localparam int FR_WE_BIT   = 6;
    localparam int FR_PAIR_BIT = 0;

    localparam int N_TRAPS = 6;
    localparam logic [ADDR_W-1:0] TRAP_ADDR [N_TRAPS] =
        '{16'h0000, 16'h0008, 16'h0038, 16'h0066, 16'h04C6, 16'h0562};
    localparam logic [7:0]        TRAP_PAGE = 8'h3D;
    localparam logic [ADDR_W-4:0] OFF_BASE  = 13'h03FF; // 1FF8h >> 3

    typedef struct packed {
        logic active;
        logic wr_en;
        logic pair;
    } mode_state_t;

    typedef enum logic [1:0] {
        FC_PLAIN = 2'd0,
        FC_TRAP  = 2'd1,
        FC_OFF   = 2'd2
    } fetch_class_t;

    function automatic fetch_class_t classify(input logic [ADDR_W-1:0] a);
        fetch_class_t c;
        c = FC_PLAIN;
        if (a[ADDR_W-1:3] == OFF_BASE) c = FC_OFF;
        if (a[ADDR_W-1:8] == TRAP_PAGE) c = FC_TRAP;
        for (int i = 0; i < N_TRAPS; i++)
            if (a == TRAP_ADDR[i]) c = FC_TRAP;
        return c;
    endfunction

    function automatic logic activates(input logic [DATA_W-1:0] d,
                                       input logic prot_set,
                                       input logic jumper_open);
        return jumper_open && !d[STD_FORCE_BIT] && d[STD_BANKHI_BIT]
               && (prot_set || d[STD_PROT_BIT]);
    endfunction

endpackage

// File: rtl/allram_mode_reg.sv
module allram_mode_reg
    import allram_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          mapram_i,
    input  logic          jumper_open_i,
    output mode_state_t   st_o
);

    mode_state_t st_q;
    logic        enter_req;

    assign enter_req = wr_i && activates(wdata_i[DATA_W-1:0], mapram_i, jumper_open_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (!jumper_open_i) begin
            st_q.active <= 1'b0;
        end else if (wr_i) begin
            if (st_q.active) begin
                if (wdata_i[FR_EXIT_BIT]) begin
                    st_q.active <= 1'b0;
                end else begin
                    st_q.wr_en <= wdata_i[FR_WE_BIT];
                    st_q.pair  <= wdata_i[FR_PAIR_BIT];
                end
            end else if (enter_req) begin
                st_q.active <= 1'b1;
                st_q.wr_en  <= wdata_i[STD_PROT_BIT];
                st_q.pair   <= 1'b0;
            end
        end
    end

    assign st_o = st_q;

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !st_q.active); // R10

    AST_JUMPER_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !jumper_open_i |=> !st_q.active); // R6

    AST_EXIT_WRITE: assert property (@(posedge clk) disable iff (rst)
        st_q.active && wr_i && wdata_i[FR_EXIT_BIT] |=> !st_q.active); // R4

    AST_ENTRY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !st_q.active && wr_i && jumper_open_i && !wdata_i[STD_FORCE_BIT]
        && wdata_i[STD_BANKHI_BIT] && (mapram_i || wdata_i[STD_PROT_BIT])
        |=> st_q.active && !st_q.pair
            && (st_q.wr_en == $past(wdata_i[STD_PROT_BIT]))); // R1

    AST_FIELD_UPDATE: assert property (@(posedge clk) disable iff (rst)
        st_q.active && wr_i && jumper_open_i && !wdata_i[FR_EXIT_BIT]
        |=> st_q.active && (st_q.wr_en == $past(wdata_i[FR_WE_BIT]))
            && (st_q.pair == $past(wdata_i[FR_PAIR_BIT]))); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !st_q.active && (!wr_i || wdata_i[STD_FORCE_BIT] || !wdata_i[STD_BANKHI_BIT])
        |=> !st_q.active); // R11

    wire unused_hi = ^wdata_i;

endmodule

// File: rtl/allram_nmi_gate.sv
module allram_nmi_gate
    import allram_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic          fetch_i,
    input  logic          rfsh_i,
    input  logic [AW-1:0] addr_i,
    output logic          nmi_ok_o
);

    logic         nmi_q;
    logic         armed_q;
    fetch_class_t fc;

    assign fc = classify(addr_i[ADDR_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            nmi_q   <= 1'b1;
            armed_q <= 1'b0;
        end else if (fetch_i) begin
            unique case (fc)
                FC_TRAP: begin
                    nmi_q   <= 1'b0;
                    armed_q <= 1'b0;
                end
                FC_OFF:  armed_q <= 1'b1;
                default: armed_q <= 1'b0;
            endcase
        end else if (rfsh_i) begin
            if (armed_q) nmi_q <= 1'b1;
            armed_q <= 1'b0;
        end
    end

    assign nmi_ok_o = nmi_q;

    AST_TRAP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        en_i && fetch_i && (fc == FC_TRAP) |=> !nmi_q); // R7

    AST_ARMED_REFRESH: assert property (@(posedge clk) disable iff (rst)
        en_i && !fetch_i && rfsh_i && armed_q |=> nmi_q); // R8

    AST_OFF_FETCH_WAITS: assert property (@(posedge clk) disable iff (rst)
        en_i && fetch_i && (fc == FC_OFF) && !nmi_q |=> !nmi_q); // R8

    AST_BARE_REFRESH: assert property (@(posedge clk) disable iff (rst)
        en_i && !fetch_i && rfsh_i && !armed_q |=> $stable(nmi_q)); // R8

    AST_IDLE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> nmi_q); // R9

    wire unused_addr = ^addr_i;

endmodule

// File: rtl/allram_pager.sv
module allram_pager
    import allram_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr_i,
    input  logic [DW-1:0] reg_wdata_i,
    input  logic          mapram_i,
    input  logic          jumper_open_i,
    input  logic          fetch_i,
    input  logic          rfsh_i,
    input  logic [AW-1:0] fetch_addr_i,
    output logic          allram_o,
    output logic          pair_sel_o,
    output logic          ram_we_o,
    output logic          nmi_en_o
);

    mode_state_t st;
    logic        gate_ok;

    allram_mode_reg #(.DW(DW)) u_mode (
        .clk           (clk),
        .rst           (rst),
        .wr_i          (reg_wr_i),
        .wdata_i       (reg_wdata_i),
        .mapram_i      (mapram_i),
        .jumper_open_i (jumper_open_i),
        .st_o          (st)
    );

    // closing the jumper takes effect without waiting for a clock edge
    assign allram_o   = st.active && jumper_open_i;
    assign pair_sel_o = allram_o && st.pair;
    assign ram_we_o   = allram_o && st.wr_en;

    allram_nmi_gate #(.AW(AW)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .en_i     (allram_o),
        .fetch_i  (fetch_i),
        .rfsh_i   (rfsh_i),
        .addr_i   (fetch_addr_i),
        .nmi_ok_o (gate_ok)
    );

    assign nmi_en_o = !allram_o || gate_ok;

    AST_OUTPUTS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !allram_o |-> !ram_we_o && !pair_sel_o && nmi_en_o); // R3

endmodule

// File: tb/tb_allram_pager.sv
`timescale 1ns/1ps
module tb_allram_pager;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic        mapram = 1'b0;
    logic        jumper_open = 1'b1;
    logic        fetch = 1'b0;
    logic        rfsh = 1'b0;
    logic [15:0] faddr = '0;
    logic        allram, pair_sel, ram_we, nmi_en;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    allram_pager dut (
        .clk(clk), .rst(rst), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
        .mapram_i(mapram), .jumper_open_i(jumper_open), .fetch_i(fetch),
        .rfsh_i(rfsh), .fetch_addr_i(faddr), .allram_o(allram),
        .pair_sel_o(pair_sel), .ram_we_o(ram_we), .nmi_en_o(nmi_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; reg_wr = 1'b0; fetch = 1'b0; rfsh = 1'b0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic do_fetch(input logic [15:0] a);
        fetch = 1'b1; faddr = a;
        step();
        fetch = 1'b0;
    endtask

    task automatic do_rfsh();
        rfsh = 1'b1;
        step();
        rfsh = 1'b0;
    endtask

    function automatic logic is_trap(input logic [15:0] a);
        return a == 16'h0000 || a == 16'h0008 || a == 16'h0038 || a == 16'h0066
            || a == 16'h04C6 || a == 16'h0562 || a[15:8] == 8'h3D;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R10 reset state
        chk("R10 allram", allram, 0);
        chk("R10 we", ram_we, 0);
        chk("R10 pair", pair_sel, 0);
        chk("R10 nmi", nmi_en, 1);

        // R1 / R11 sweep of activation writes from the inactive state
        for (int mp = 0; mp < 2; mp++) begin
            for (int jo = 0; jo < 2; jo++) begin
                for (int d = 0; d < 256; d++) begin
                    logic [7:0] dv;
                    logic       e;
                    dv = 8'(d);
                    do_reset();
                    mapram = mp[0]; jumper_open = jo[0];
                    wr(dv);
                    e = jo[0] && !dv[7] && dv[1] && (mp[0] || dv[6]);
                    chk(e ? "R1 entry" : "R11 no entry", allram, e);
                    chk("R1 we", ram_we, e && dv[6]);
                    chk("R1 pair", pair_sel, 0);
                    chk("R9 nmi on entry", nmi_en, 1);
                end
            end
        end

        // R2 / R3 / R4 / R5 sweep in the mode
        do_reset();
        mapram = 1'b1; jumper_open = 1'b1;
        wr(8'h42);
        chk("R1 42h", {allram, ram_we}, 2'b11);
        for (int d = 0; d < 256; d++) begin
            logic [7:0] dv;
            dv = 8'(d);
            wr(dv);
            if (dv[7]) begin
                chk("R4 exit", allram, 0);
                chk("R3 we off", ram_we, 0);
                chk("R3 pair off", pair_sel, 0);
                wr(8'h02);
                chk("R5 re-entry", allram, 1);
                chk("R5 we", ram_we, 0);
            end else begin
                chk("R2 stay", allram, 1);
                chk("R2 we", ram_we, dv[6]);
                chk("R2 pair", pair_sel, dv[0]);
            end
        end

        // R6 jumper close
        wr(8'h41);
        chk("R2 pair1", pair_sel, 1);
        do_fetch(16'h0066);
        chk("R7 trap", nmi_en, 0);
        jumper_open = 1'b0;
        #1;
        chk("R6 same cycle", allram, 0);
        chk("R6 we", ram_we, 0);
        chk("R9 nmi outside", nmi_en, 1);
        step();
        jumper_open = 1'b1;
        step();
        chk("R6 stays off", allram, 0);
        wr(8'h42);
        chk("R5 after jumper", allram, 1);
        chk("R9 nmi fresh", nmi_en, 1);

        // R8 bare refresh and exit reset of gate
        do_fetch(16'h3D00);
        chk("R7 3D00", nmi_en, 0);
        do_rfsh();
        chk("R8 bare refresh", nmi_en, 0);
        do_fetch(16'h1FFF);
        chk("R8 off fetch waits", nmi_en, 0);
        do_fetch(16'h1234);
        do_rfsh();
        chk("R8 disarmed", nmi_en, 0);
        wr(8'h80);
        chk("R9 exit", nmi_en, 1);
        wr(8'h42);
        chk("R9 re-entry nmi", nmi_en, 1);

        // R7 / R8 address sweep
        for (int a = 0; a < 16384; a++) begin
            logic [15:0] av;
            av = 16'(a);
            do_fetch(av);
            chk(is_trap(av) ? "R7 trap fetch" : "R7 plain fetch", nmi_en, !is_trap(av));
            do_fetch(16'h1FF8);
            chk("R8 before refresh", nmi_en, !is_trap(av));
            do_rfsh();
            chk("R8 after refresh", nmi_en, 1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule